// File: doc/BRIEF.md
# Four-Lane Comma-Aligned Deskew Bonder

This block joins four independently recovered 10-bit symbol lanes into one 40-bit bonded word. The lanes carry the same comma pattern at the same moment on the transmit side, but each lane reaches the receiver with its own latency. The bonder watches each lane for the first valid, non-comma symbol that follows a run of commas. It measures how many cycles each lane trails the earliest one, and delays each lane through an 8-entry history buffer so that those first-data symbols leave all four lanes on the same clock.

Measurement only starts on a lane whose symbol aligner reports that it is re-synchronising. Once the delayed first-data symbols have been seen together on the output, the bonder declares the lanes locked and freezes every lane delay until a restart. If the lanes spread further apart than the deskew window of four cycles, the bonder raises a failure flag instead. It keeps all delays at zero and holds the flag until a restart. All lanes are assumed to be in the same clock domain.

Top module: `lane_bond_deskew`

## Requirements
- R1: A lane's first-data event occurs in a cycle where its resync input is 1, valid is 1 and comma is 0, and the most recent earlier symbol on that lane with valid=1 was a comma. Symbols with valid=0 between the comma run and the data neither arm nor disarm the lane.
- R2: Arrival offsets are counted in cycles from the first lane's first-data event, which has offset 0. Once all four lanes have arrived, each lane's delay is the largest offset minus that lane's own offset. Lane i's delay sits in `lane_delay[3*i +: 3]`.
- R3: Lane i's symbols appear on `bond_data[10*i +: 10]`. The value shown in a cycle is the symbol that lane captured `lane_delay` cycles earlier, counted in clock edges, with one register stage at delay 0.
- R4: The new delays take effect on the clock edge that captures the last lane's first-data symbol. From that edge on, the four first-data symbols appear on `bond_data` together.
- R5: `bond_locked` rises one clock after the aligned first-data symbols appear, and only if all four delayed lanes carry their first-data mark in the same cycle.
- R6: When all lanes arrive in the same cycle, every delay stays 0 and the bonder still locks.
- R7: While `bond_locked` is 1, the delays do not change, whatever comma and data sequences arrive, until a restart.
- R8: Offsets 0 to 3 are accepted. If a lane has not arrived by the edge at offset 3, `skew_fail` rises after that edge. It then stays 1, with `bond_locked` at 0 and all delays at 0, until a restart.
- R9: When `bond_restart` is 1 at a clock edge, the outputs after that edge show every delay at 0, `bond_locked` at 0 and `skew_fail` at 0, and measurement starts over.
- R10: During reset, `bond_data`, `lane_delay`, `bond_locked` and `skew_fail` are all 0.
- R11: A lane whose resync input is 0 never produces a first-data event. If that holds the lane back, the window runs out as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_data | input | 40 | Four 10-bit recovered symbols, lane i in bits 10*i+9:10*i |
| lane_comma | input | 4 | Per-lane flag: symbol is a comma |
| lane_valid | input | 4 | Per-lane flag: symbol decoded without error |
| lane_resync | input | 4 | Per-lane flag: lane aligner is re-synchronising |
| bond_restart | input | 1 | Drop lock or failure and measure again |
| bond_data | output | 40 | Deskewed bonded symbols, lane i in bits 10*i+9:10*i |
| lane_delay | output | 12 | Per-lane delay, 3 bits per lane |
| bond_locked | output | 1 | All lanes aligned; delays frozen |
| skew_fail | output | 1 | Skew exceeded the deskew window |

## Verification
The assertions assume that `bond_restart` is the only way out of the locked or failed condition. They also assume that the per-lane flags are stable between clock edges, so a delay held in the locked state is an observable invariant. The stimulus builds every lane stream from the same recipe: filler data, a six-symbol comma run, the first-data symbol at a chosen offset, then counting data. Each change of operating condition is issued as a single-cycle restart. Offsets are chosen to reach the window edge on purpose, both at the largest accepted skew and one cycle past it, while all other flags stay clean.

// File: rtl/lane_bond_pkg.sv
package lane_bond_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_ALIGN  = 2'd1,
        ST_LOCKED = 2'd2,
        ST_FAIL   = 2'd3
    } bond_state_e;

endpackage

// File: rtl/bond_first_data.sv
module bond_first_data (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_valid,
    input  logic sym_comma,
    input  logic sym_resync,
    output logic first_data
);
    logic armed_d, armed_q;

    always_comb begin
        first_data = sym_resync & sym_valid & ~sym_comma & armed_q;
        if (!sym_resync) begin
            armed_d = 1'b0;
        end else if (sym_valid) begin
            armed_d = sym_comma;
        end else begin
            armed_d = armed_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= armed_d;
        end
    end
endmodule

// File: rtl/bond_delay_line.sv
module bond_delay_line #(
    parameter  int SYM_W = 10,
    parameter  int DEPTH = 8,
    localparam int DLY_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] in_sym,
    input  logic             in_first,
    input  logic [DLY_W-1:0] tap_sel,
    output logic [SYM_W-1:0] out_sym,
    output logic             out_first
);
    logic [SYM_W:0] hist_d [DEPTH];
    logic [SYM_W:0] hist_q [DEPTH];

    always_comb begin
        hist_d[0] = {in_first, in_sym};
        for (int k = 1; k < DEPTH; k++) begin
            hist_d[k] = hist_q[k-1];
        end
        {out_first, out_sym} = hist_q[tap_sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                hist_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                hist_q[k] <= hist_d[k];
            end
        end
    end
endmodule

// File: rtl/bond_align_ctrl.sv
module bond_align_ctrl
    import lane_bond_pkg::*;
#(
    parameter  int NUM_LANES = 4,
    parameter  int DEPTH     = 8,
    parameter  int WINDOW    = 4,
    localparam int DLY_W     = $clog2(DEPTH),
    localparam int CNT_W     = $clog2(WINDOW + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LANES-1:0]       first_data,
    input  logic [NUM_LANES-1:0]       tap_first,
    input  logic                       restart,
    output logic [NUM_LANES*DLY_W-1:0] delay_flat,
    output logic                       locked,
    output logic                       failed
);
    typedef struct packed {
        bond_state_e                      state;
        logic                             started;
        logic [CNT_W-1:0]                 cnt;
        logic [NUM_LANES-1:0]             seen;
        logic [NUM_LANES-1:0][DLY_W-1:0]  arr;
        logic [NUM_LANES-1:0][DLY_W-1:0]  dly;
    } ctrl_s;

    ctrl_s            d, q;
    logic [DLY_W-1:0] latest;

    always_comb begin
        d      = q;
        latest = '0;
        unique case (q.state)
            ST_HUNT: begin
                if (q.started || (|first_data)) begin
                    d.started = 1'b1;
                    d.cnt     = q.started ? q.cnt + 1'b1 : CNT_W'(1);
                    for (int i = 0; i < NUM_LANES; i++) begin
                        if (first_data[i] && !q.seen[i]) begin
                            d.seen[i] = 1'b1;
                            d.arr[i]  = q.started ? DLY_W'(q.cnt) : '0;
                        end
                    end
                    if (&d.seen) begin
                        for (int i = 0; i < NUM_LANES; i++) begin
                            if (d.arr[i] > latest) begin
                                latest = d.arr[i];
                            end
                        end
                        for (int i = 0; i < NUM_LANES; i++) begin
                            d.dly[i] = latest - d.arr[i];
                        end
                        d.state   = ST_ALIGN;
                        d.started = 1'b0;
                        d.cnt     = '0;
                        d.seen    = '0;
                        d.arr     = '0;
                    end else if (q.started && q.cnt == CNT_W'(WINDOW - 1)) begin
                        d.state   = ST_FAIL;
                        d.started = 1'b0;
                        d.cnt     = '0;
                        d.seen    = '0;
                        d.arr     = '0;
                    end
                end
            end
            ST_ALIGN: begin
                if (&tap_first) begin
                    d.state = ST_LOCKED;
                end else begin
                    d.state = ST_HUNT;
                    d.dly   = '0;
                end
            end
            default: begin
            end
        endcase
        if (restart) begin
            d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_LANES; i++) begin
            delay_flat[i*DLY_W +: DLY_W] = q.dly[i];
        end
        locked = (q.state == ST_LOCKED);
        failed = (q.state == ST_FAIL);
    end
endmodule

// File: rtl/lane_bond_deskew.sv
module lane_bond_deskew #(
    parameter  int NUM_LANES = 4,
    parameter  int SYM_W     = 10,
    parameter  int DEPTH     = 8,
    parameter  int WINDOW    = 4,
    localparam int DLY_W     = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LANES*SYM_W-1:0] lane_data,
    input  logic [NUM_LANES-1:0]       lane_comma,
    input  logic [NUM_LANES-1:0]       lane_valid,
    input  logic [NUM_LANES-1:0]       lane_resync,
    input  logic                       bond_restart,
    output logic [NUM_LANES*SYM_W-1:0] bond_data,
    output logic [NUM_LANES*DLY_W-1:0] lane_delay,
    output logic                       bond_locked,
    output logic                       skew_fail
);
    logic [NUM_LANES-1:0] first_data;
    logic [NUM_LANES-1:0] tap_first;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        bond_first_data u_detect (
            .clk        (clk),
            .rst_n      (rst_n),
            .sym_valid  (lane_valid[g]),
            .sym_comma  (lane_comma[g]),
            .sym_resync (lane_resync[g]),
            .first_data (first_data[g])
        );

        bond_delay_line #(
            .SYM_W (SYM_W),
            .DEPTH (DEPTH)
        ) u_delay (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_sym    (lane_data[g*SYM_W +: SYM_W]),
            .in_first  (first_data[g]),
            .tap_sel   (lane_delay[g*DLY_W +: DLY_W]),
            .out_sym   (bond_data[g*SYM_W +: SYM_W]),
            .out_first (tap_first[g])
        );
    end

    bond_align_ctrl #(
        .NUM_LANES (NUM_LANES),
        .DEPTH     (DEPTH),
        .WINDOW    (WINDOW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_data (first_data),
        .tap_first  (tap_first),
        .restart    (bond_restart),
        .delay_flat (lane_delay),
        .locked     (bond_locked),
        .failed     (skew_fail)
    );
endmodule

// File: rtl/lane_bond_deskew_chk.sv
module lane_bond_deskew_chk #(
    parameter  int NUM_LANES = 4,
    parameter  int DEPTH     = 8,
    parameter  int WINDOW    = 4,
    localparam int DLY_W     = $clog2(DEPTH)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bond_restart,
    input logic [NUM_LANES*DLY_W-1:0] lane_delay,
    input logic                       bond_locked,
    input logic                       skew_fail,
    input logic [NUM_LANES-1:0]       tap_first
);
    // R7
    frozen_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bond_locked && !bond_restart) |=> $stable(lane_delay));

    // R8
    fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bond_locked && skew_fail));

    // R8
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (skew_fail && !bond_restart) |=> (skew_fail && lane_delay == '0));

    // R9
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bond_restart |=> (lane_delay == '0 && !bond_locked && !skew_fail));

    // R5
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bond_locked) |-> $past(&tap_first));

    // R2
    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NUM_LANES; i++) begin
                delay_range_chk: assert (lane_delay[i*DLY_W +: DLY_W] < WINDOW);
            end
        end
    end
endmodule

bind lane_bond_deskew lane_bond_deskew_chk #(
    .NUM_LANES (NUM_LANES),
    .DEPTH     (DEPTH),
    .WINDOW    (WINDOW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bond_restart (bond_restart),
    .lane_delay   (lane_delay),
    .bond_locked  (bond_locked),
    .skew_fail    (skew_fail),
    .tap_first    (tap_first)
);

// File: tb/lane_bond_deskew_tb.sv
module lane_bond_deskew_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;
    localparam int W  = 10;
    localparam int DW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL*W-1:0] lane_data = '0;
    logic [NL-1:0]   lane_comma = '0;
    logic [NL-1:0]   lane_valid = '0;
    logic [NL-1:0]   lane_resync = '0;
    logic            bond_restart = 1'b0;
    logic [NL*W-1:0] bond_data;
    logic [NL*DW-1:0] lane_delay;
    logic            bond_locked;
    logic            skew_fail;

    lane_bond_deskew u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .lane_data    (lane_data),
        .lane_comma   (lane_comma),
        .lane_valid   (lane_valid),
        .lane_resync  (lane_resync),
        .bond_restart (bond_restart),
        .bond_data    (bond_data),
        .lane_delay   (lane_delay),
        .bond_locked  (bond_locked),
        .skew_fail    (skew_fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int              at;
        logic [NL*W-1:0] data;
        logic [NL*DW-1:0] dly;
        logic            locked;
        logic            fail;
        string           req;
    } exp_t;

    exp_t sb[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 0;

    int       sc_s[NL] = '{1000000, 1000000, 1000000, 1000000};
    int       sc_inv = -1;
    logic [NL-1:0] sc_rs = 4'hF;
    int       exp_d[NL] = '{0, 0, 0, 0};

    // {valid, comma, symbol} of lane i at sampling edge e
    function automatic logic [11:0] lane_in(int i, int e);
        logic [7:0] t;
        if (i == sc_inv && e == sc_s[i] - 1) return {1'b0, 1'b0, 10'h3FF};
        if (e >= sc_s[i] - 6 && e < sc_s[i]) return {1'b1, 1'b1, 10'h0FA};
        if (e < sc_s[i]) return {1'b1, 1'b0, 2'(i), 8'h55};
        t = 8'(e - sc_s[i]);
        return {1'b1, 1'b0, 2'(i), t};
    endfunction

    function automatic logic [NL*W-1:0] exp_data(int e);
        logic [NL*W-1:0] r;
        logic [11:0]     w;
        for (int i = 0; i < NL; i++) begin
            w = lane_in(i, e - exp_d[i]);
            r[i*W +: W] = w[9:0];
        end
        return r;
    endfunction

    function automatic logic [NL*DW-1:0] exp_dly();
        logic [NL*DW-1:0] r;
        for (int i = 0; i < NL; i++) r[i*DW +: DW] = DW'(exp_d[i]);
        return r;
    endfunction

    task automatic push(int at, logic [NL*W-1:0] data, logic lk, logic fl, string req);
        exp_t e;
        e.at = at; e.data = data; e.dly = exp_dly();
        e.locked = lk; e.fail = fl; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: compares at the falling edge after the edge numbered cyc
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at < cyc) begin
            n_vec++; n_bad++;
            $display("FAIL %s: check at cycle %0d missed (now %0d), expected it", sb[0].req, sb[0].at, cyc);
            void'(sb.pop_front());
        end
        if (sb.size() > 0 && sb[0].at == cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (bond_data !== e.data || lane_delay !== e.dly ||
                bond_locked !== e.locked || skew_fail !== e.fail) begin
                n_bad++;
                $display("FAIL %s @%0d: got data=%h dly=%h lk=%b fl=%b, expected data=%h dly=%h lk=%b fl=%b",
                         e.req, cyc, bond_data, lane_delay, bond_locked, skew_fail,
                         e.data, e.dly, e.locked, e.fail);
            end
        end
    end

    task automatic step();
        logic [11:0] w;
        int e;
        @(posedge clk);
        #1;
        e = cyc + 1;
        for (int i = 0; i < NL; i++) begin
            w = lane_in(i, e);
            lane_valid[i]       = w[11];
            lane_comma[i]       = w[10];
            lane_data[i*W +: W] = w[9:0];
            lane_resync[i]      = sc_rs[i];
        end
    endtask

    task automatic do_restart();
        int e;
        e = cyc + 2;
        for (int i = 0; i < NL; i++) exp_d[i] = 0;
        step();
        bond_restart = 1'b1;
        push(e, exp_data(e), 1'b0, 1'b0, "R9 restart clears");
        step();
        bond_restart = 1'b0;
        repeat (3) step();
    endtask

    // mode 0: expect lock, 1: expect frozen delays, 2: expect window failure
    task automatic run_scn(int o0, int o1, int o2, int o3, logic [NL-1:0] rs,
                           int inv, int mode, string tag);
        int base, mx, lst;
        int o[NL];
        o = '{o0, o1, o2, o3};
        base = cyc + 12;
        mx = 0;
        for (int i = 0; i < NL; i++) begin
            sc_s[i] = base + o[i];
            if (o[i] > mx) mx = o[i];
        end
        sc_rs = rs;
        sc_inv = inv;
        lst = base + mx;
        if (mode == 0) begin
            push(lst - 1, exp_data(lst - 1), 1'b0, 1'b0, {tag, " R3 before align"});
            for (int i = 0; i < NL; i++) exp_d[i] = lst - sc_s[i];
            push(lst, exp_data(lst), 1'b0, 1'b0, {tag, " R2 R4 aligned first data"});
            push(lst + 1, exp_data(lst + 1), 1'b1, 1'b0, {tag, " R5 lock"});
            push(lst + 3, exp_data(lst + 3), 1'b1, 1'b0, {tag, " R3 delayed stream"});
        end else if (mode == 1) begin
            push(lst + 1, exp_data(lst + 1), 1'b1, 1'b0, {tag, " R7 delays frozen"});
            push(lst + 4, exp_data(lst + 4), 1'b1, 1'b0, {tag, " R7 stream on old delays"});
        end else begin
            push(base + 2, exp_data(base + 2), 1'b0, 1'b0, {tag, " R8 inside window"});
            push(base + 3, exp_data(base + 3), 1'b0, 1'b1, {tag, " R8 window expired"});
            push(base + 6, exp_data(base + 6), 1'b0, 1'b1, {tag, " R8 failure held"});
        end
        while (cyc < base + 9) step();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            n_bad += sb.size();
            for (int k = 0; k < sb.size(); k++)
                $display("FAIL %s: check at cycle %0d never reached", sb[k].req, sb[k].at);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 3000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: run did not end, got timeout, expected completion");
        summary();
    end

    initial begin
        // R10: outputs held at zero during reset
        push(2, '0, 1'b0, 1'b0, "R10 reset state");
        repeat (4) step();
        rst_n = 1'b1;
        push(cyc + 2, exp_data(cyc + 2), 1'b0, 1'b0, "R10 after reset, zero delay");
        repeat (3) step();

        run_scn(0, 0, 0, 0, 4'hF, -1, 0, "R6 zero skew");
        do_restart();
        run_scn(2, 0, 3, 1, 4'hF, -1, 0, "mixed skew");
        run_scn(1, 2, 0, 3, 4'hF, -1, 1, "relock attempt");
        do_restart();
        run_scn(0, 1, 2, 4, 4'hF, -1, 2, "skew 4");
        do_restart();
        run_scn(0, 3, 1, 2, 4'hF, -1, 0, "R8 skew 3 accepted");
        do_restart();
        run_scn(0, 0, 0, 0, 4'hE, -1, 2, "R11 lane0 not resyncing");
        do_restart();
        run_scn(1, 0, 2, 0, 4'hF, 2, 0, "R1 invalid symbol before data");
        repeat (3) step();
        summary();
    end
endmodule